// File: doc/BRIEF.md
# Bounded Up/Down Wrap Counter

This block is a synchronous counter that only ever visits the values 3 through 7. A single direction input selects counting upward or downward. When the count reaches the far end of its range, the next clock edge loads the opposite boundary instead of stepping. Counting up, 7 is followed by 3. Counting down, 3 is followed by 7. The wrap value is chosen by the registered direction, so the wrap is an edge-timed parallel load and never a combinational jump.

The direction switch arrives from the outside world with no timing relationship to the clock. It passes through a two-flop synchronizer before it steers the counter. Direction therefore changes only on a clock edge, and a step is never taken twice or in both directions.

A synchronous active-low reset returns the count to 7. If the register ever holds a value below 3, as it can at power-up before reset, the next edge loads 7. A decoder drives an active-low seven-segment pattern for the current digit.

Top module: `bounded_wrap_counter`

## Requirements
- R1: With the synchronized direction set to up (mode_up_i = 1), each edge advances the count by one, and 7 is followed by 3, giving the cycle 3, 4, 5, 6, 7, 3, …
- R2: With the synchronized direction set to down (mode_up_i = 0), each edge lowers the count by one, and 3 is followed by 7, giving the cycle 7, 6, 5, 4, 3, 7, …
- R3: rst_ni is active-low and synchronous. An edge sampled with rst_ni = 0 sets count_o to 7. Lowering rst_ni between edges leaves count_o unchanged until the next rising edge.
- R4: Reset wins over stepping and over the wrap load on the same edge. A reset edge gives 7 whether the count was 7 counting up, 3 counting down, or any other value.
- R5: A change of mode_up_i made before edge k first steers the step taken on edge k+2. The steps on edges k and k+1 still follow the old direction.
- R6: Under any pattern of mode changes, every edge without reset moves the count by exactly one legal step, up or down, in the direction the synchronizer presented. It never holds, skips or jumps to an unrelated value.
- R7: A count below 3 is replaced by 7 on the next edge. From any power-up state, the count lies in 3..7 after one clock edge, even with no reset applied.
- R8: seg_no is active-low, with bit 0 = segment a through bit 6 = segment g. Count 3 gives 7'h30, 4 gives 7'h19, 5 gives 7'h12, 6 gives 7'h02, and 7 gives 7'h78.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset, loads 7 |
| mode_up_i | input | 1 | Asynchronous direction switch, 1 = up, 0 = down |
| count_o | output | 3 | Current count, 3..7 |
| seg_no | output | 7 | Active-low segment drive, bit 0 = a, bit 6 = g |

## Verification
The assertions assume that the synchronized direction seen inside the block is a clean, settled level on each edge. They also assume that reset is sampled only at edges. The mode switch may change at any time in hardware, but the synchronizer is what makes that safe.

The stimulus drives mode_up_i and rst_ni only at falling clock edges, away from the sampling edge. This keeps the metastability window out of simulation. It sweeps every 8-bit pattern of direction changes, so each per-edge transition is compared against a reference that includes the two-edge synchronizer delay.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  localparam int unsigned SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  // active-high a..g (bit 0 = a) for decimal digits
  function automatic seg_t seg_hi(input logic [3:0] d);
    case (d)
      4'd0: seg_hi = 7'h3F;
      4'd1: seg_hi = 7'h06;
      4'd2: seg_hi = 7'h5B;
      4'd3: seg_hi = 7'h4F;
      4'd4: seg_hi = 7'h66;
      4'd5: seg_hi = 7'h6D;
      4'd6: seg_hi = 7'h7D;
      4'd7: seg_hi = 7'h07;
      4'd8: seg_hi = 7'h7F;
      4'd9: seg_hi = 7'h6F;
      default: seg_hi = '0;
    endcase
  endfunction
endpackage

// File: rtl/wrap_mode_sync.sv
module wrap_mode_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i) pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/wrap_next_state.sv
module wrap_next_state #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned LO    = 3,
  parameter int unsigned HI    = 7
) (
  input  logic             rst_ni,
  input  logic             dir_up_i,
  input  logic [WIDTH-1:0] count_i,
  output logic [WIDTH-1:0] count_d_o
);
  localparam logic [WIDTH:0]   HI_EXT = (WIDTH+1)'(HI);
  localparam logic [WIDTH-1:0] LO_V   = WIDTH'(LO);
  localparam logic [WIDTH-1:0] HI_V   = WIDTH'(HI);

  logic             in_range;
  logic             load_en;
  logic [WIDTH-1:0] load_val;

  assign in_range = (count_i >= LO_V) && ({1'b0, count_i} <= HI_EXT);
  // boundary load: direction picks which end is loaded
  assign load_en  = !in_range || (dir_up_i ? (count_i == HI_V) : (count_i == LO_V));
  assign load_val = (!in_range || !dir_up_i) ? HI_V : LO_V;

  always_comb begin
    if (!rst_ni)       count_d_o = HI_V;
    else if (load_en)  count_d_o = load_val;
    else if (dir_up_i) count_d_o = count_i + WIDTH'(1);
    else               count_d_o = count_i - WIDTH'(1);
  end
endmodule

// File: rtl/wrap_seg_decode.sv
module wrap_seg_decode
  import wrap_pkg::*;
#(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned LO    = 3,
  parameter int unsigned HI    = 7
) (
  input  logic [WIDTH-1:0] val_i,
  output seg_t             seg_no
);
  localparam logic [WIDTH:0] LO_EXT = (WIDTH+1)'(LO);
  localparam logic [WIDTH:0] HI_EXT = (WIDTH+1)'(HI);

  logic show;
  assign show   = ({1'b0, val_i} >= LO_EXT) && ({1'b0, val_i} <= HI_EXT);
  assign seg_no = show ? ~seg_hi(4'(val_i)) : '1;
endmodule

// File: rtl/bounded_wrap_counter.sv
module bounded_wrap_counter
  import wrap_pkg::*;
#(
  parameter int unsigned WIDTH       = 3,
  parameter int unsigned LO          = 3,
  parameter int unsigned HI          = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_up_i,
  output logic [WIDTH-1:0] count_o,
  output logic [SEG_W-1:0] seg_no
);
  logic             dir_up_q;
  logic [WIDTH-1:0] count_d;

  wrap_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (mode_up_i),
    .q_o   (dir_up_q)
  );

  wrap_next_state #(.WIDTH(WIDTH), .LO(LO), .HI(HI)) u_next (
    .rst_ni    (rst_ni),
    .dir_up_i  (dir_up_q),
    .count_i   (count_o),
    .count_d_o (count_d)
  );

  always_ff @(posedge clk_i) count_o <= count_d;

  wrap_seg_decode #(.WIDTH(WIDTH), .LO(LO), .HI(HI)) u_seg (
    .val_i  (count_o),
    .seg_no (seg_no)
  );
endmodule

// File: rtl/wrap_counter_checker.sv
module wrap_counter_checker #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned LO    = 3,
  parameter int unsigned HI    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dir_up_i,
  input logic [WIDTH-1:0] count_i
);
  localparam logic [WIDTH-1:0] LO_V = WIDTH'(LO);
  localparam logic [WIDTH-1:0] HI_V = WIDTH'(HI);

  a_r1_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_up_i && count_i >= LO_V && count_i < HI_V) |=> count_i == $past(count_i) + WIDTH'(1));

  a_r1_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_up_i && count_i == HI_V) |=> count_i == LO_V);

  a_r2_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_up_i && count_i > LO_V && count_i <= HI_V) |=> count_i == $past(count_i) - WIDTH'(1));

  a_r2_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_up_i && count_i == LO_V) |=> count_i == HI_V);

  // R3 / R4: reset edge always yields HI
  a_r4_reset_load: assert property (@(posedge clk_i)
    !rst_ni |=> count_i == HI_V);

  a_r7_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i < LO_V) |=> count_i == HI_V);
endmodule

bind bounded_wrap_counter wrap_counter_checker #(.WIDTH(WIDTH), .LO(LO), .HI(HI)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dir_up_i (dir_up_q),
  .count_i  (count_o)
);

// File: tb/tb_bounded_wrap_counter.sv
`timescale 1ns/1ps
module tb_bounded_wrap_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       mode = 1'b1;
  logic [2:0] cnt;
  logic [6:0] seg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bounded_wrap_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_up_i(mode), .count_o(cnt), .seg_no(seg)
  );

  function automatic int up_of(input int v);
    return (v == 7) ? 3 : v + 1;
  endfunction
  function automatic int dn_of(input int v);
    return (v == 3) ? 7 : v - 1;
  endfunction
  function automatic logic [6:0] seg_exp(input int v);
    case (v)
      3: return 7'h30;
      4: return 7'h19;
      5: return 7'h12;
      6: return 7'h02;
      7: return 7'h78;
      default: return 7'h7F;
    endcase
  endfunction

  // reference: two-edge direction delay, reset wins, boundary wrap
  int m_cnt = 0;
  bit m_s1 = 1'b0, m_s2 = 1'b0;
  always @(posedge clk) begin
    m_s1 <= mode;
    m_s2 <= m_s1;
    if (!rst_n)        m_cnt <= 7;
    else if (m_cnt < 3) m_cnt <= 7;
    else if (m_s2)     m_cnt <= up_of(m_cnt);
    else               m_cnt <= dn_of(m_cnt);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cyc_cmp(input string tag);
    cyc();
    chk(tag, int'(cnt), m_cnt);
    chk("R8", int'(seg), int'(seg_exp(int'(cnt))));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int c0, c1, c2;
    // R7: free-running from power-up state, no reset
    repeat (2) cyc();
    chk("R7", int'(cnt >= 3 && cnt <= 7), 1);

    // R3: synchronous reset
    rst_n = 1'b0;
    repeat (3) cyc();
    chk("R3", int'(cnt), 7);
    chk("R8", int'(seg), 7'h78);
    rst_n = 1'b1;

    // R1: up run
    repeat (12) cyc_cmp("R1");

    // R5: direction latency
    c0 = int'(cnt);
    mode = 1'b0;
    cyc(); c1 = int'(cnt); chk("R5", c1, up_of(c0));
    cyc(); c2 = int'(cnt); chk("R5", c2, up_of(c1));
    cyc(); chk("R5", int'(cnt), dn_of(c2));

    // R2: down run
    repeat (12) cyc_cmp("R2");

    // R3: reset lowered mid-cycle does not act before the edge
    while (cnt != 4) cyc();
    #0.5 rst_n = 1'b0;
    #1 chk("R3", int'(cnt), 4);
    cyc(); chk("R3", int'(cnt), 7);
    rst_n = 1'b1;

    // R4: reset at down-wrap point (3)
    while (cnt != 3) cyc();
    rst_n = 1'b0; cyc(); chk("R4", int'(cnt), 7); rst_n = 1'b1;

    // R4: reset at up-wrap point (7) must not load 3
    mode = 1'b1;
    repeat (3) cyc();
    while (cnt != 7) cyc();
    rst_n = 1'b0; cyc(); chk("R4", int'(cnt), 7);
    cyc(); chk("R4", int'(cnt), 7); rst_n = 1'b1;

    // R4: reset mid-range
    while (cnt != 5) cyc();
    rst_n = 1'b0; cyc(); chk("R4", int'(cnt), 7); rst_n = 1'b1;

    // R6: every 8-bit direction pattern
    for (int p = 0; p < 256; p++) begin
      for (int b = 0; b < 8; b++) begin
        mode = p[b];
        cyc_cmp("R6");
      end
    end

    // R6: fast toggling
    for (int i = 0; i < 40; i++) begin
      mode = ~mode;
      cyc_cmp("R6");
    end

    summary();
  end
endmodule